// File: doc/BRIEF.md
# NMI Snapshot Overlay Pager

This block sits on a Z80 bus as the control part of a freeze-button expansion. Pressing the button raises a non-maskable interrupt. When the CPU then fetches the NMI vector opcode, a private 8 KB ROM and an 8 KB RAM are switched over the bottom 16 KB of the address space. The service code in that overlay later uses a few I/O accesses to acknowledge the interrupt, to hide the device from the port map and to switch the overlay off again.

Every bus strobe, the address, data bit 0, reset and the button are sampled on a system clock. The block keeps four flags: interrupt pending, hidden, paged in and host all-RAM mode. A flag that a bus access moves changes only once the qualifying strobe has been released, which stands in for flip-flops clocked by a strobe edge. The interrupt line and both overlay chip enables are registered active-low outputs.

Top module: `snap_pager`

## Requirements
- R1: After reset nmiN, romCeN and ramCeN are all high. The device is hidden and paged out, and the host all-RAM flag is clear.
- R2: While no interrupt is pending, a high level on freezeBtn sets the pending flag and makes the device visible. nmiN goes low within three clocks.
- R3: nmiN is low exactly when an interrupt is pending and the host all-RAM flag is clear. It is registered one clock after those flags.
- R4: A memory read with M1 active at address 0x0066 pages the overlay in. It must also be qualified by a pending interrupt and a clear all-RAM flag. A read at 0x0066 without M1, or an M1 read at any other address, leaves the paging unchanged.
- R5: An I/O write whose address bits 6..0 equal 0111111 clears the pending flag, whatever A7 and A15..A8 are. Other low seven-bit values leave it set.
- R6: An I/O write whose low byte is exactly 0x3F hides the device. A write to 0xBF does not.
- R7: An I/O read whose low byte is 0x3F pages the overlay out, but only while the device is visible. A read to 0xBF has no effect, and so does a read while the device is hidden.
- R8: An I/O write with A15..A12 = 0001 and low byte 0xFD loads D0 into the all-RAM flag, whatever A11..A8 are. A value of 1 masks nmiN and blocks the page-in of R4. Writes with another upper nibble leave the flag unchanged.
- R9: While paged in, a memory request with A15 = A14 = 0 drives romCeN low when A13 = 0 and ramCeN low when A13 = 1. At any other address, or while paged out, both stay high. The two enables are never low together.
- R10: A flag moved by a bus access changes only after the strobe is released. While an acknowledging write is held, nmiN stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all bus signals are sampled |
| rstN | input | 1 | Active-low asynchronous reset |
| iorqN | input | 1 | I/O request strobe, active low |
| mreqN | input | 1 | Memory request strobe, active low |
| m1N | input | 1 | Opcode fetch cycle marker, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 16 | CPU address bus |
| d0 | input | 1 | Data bus bit 0 |
| freezeBtn | input | 1 | Freeze push-button, high while pressed |
| nmiN | output | 1 | Non-maskable interrupt request to the CPU, active low |
| romCeN | output | 1 | Overlay ROM chip enable, active low |
| ramCeN | output | 1 | Overlay RAM chip enable, active low |

## Verification
The acknowledge decode is swept over the port byte 0x3F and the eight ports that differ from it in one bit. The expected interrupt state is computed from bits 6..0, so this sweep separates the ignored A7 from the bits that are decoded. The chip enables are swept over all sixteen upper address nibbles while paged in, then sampled again while paged out, which separates the A13 select from the A15/A14 window and from the paging flag. The page-in is tried with a non-M1 read at the vector, with an M1 read one address off and with the real fetch. The port read is tried with A7 high, while hidden and while visible. The mode port is tried with the wrong upper nibble and with other middle bits, and each case is told apart through nmiN and the enables.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  // Flag state held by the datapath
  typedef struct packed {
    logic nmiPend;
    logic hidden;
    logic pagedIn;
    logic allRam;
  } ovlFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic btnPress;
    logic nmiClr;
    logic hideSet;
    logic pageLoad;
    logic pageVal;
    logic allRamLoad;
    logic allRamVal;
    logic fetchHit;
    logic romHit;
    logic ramHit;
  } ovlStrobe_t;

endpackage

// File: rtl/ovl_bus_ctrl.sv
module ovl_bus_ctrl
  import ovl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] NMI_VEC   = 16'h0066,
  parameter logic [7:0]  PAGE_PORT = 8'h3F,
  parameter logic [7:0]  MODE_LO   = 8'hFD,
  parameter logic [3:0]  MODE_HI   = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iorqN,
  input  logic              mreqN,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d0,
  input  logic              freezeBtn,
  input  ovlFlags_t         flg,
  output ovlStrobe_t        strb
);

  localparam int TOP     = ADDR_W - 1;
  localparam int NUM_DEC = 5;
  localparam int D_CLR   = 0;
  localparam int D_HIDE  = 1;
  localparam int D_PAGE  = 2;
  localparam int D_MODE  = 3;
  localparam int D_FETCH = 4;

  // Bus sample stage
  logic              iorqQ, mreqQ, m1Q, rdQ, wrQ, d0Q, btnQ;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iorqQ <= 1'b1;
      mreqQ <= 1'b1;
      m1Q   <= 1'b1;
      rdQ   <= 1'b1;
      wrQ   <= 1'b1;
      d0Q   <= 1'b0;
      btnQ  <= 1'b0;
      addrQ <= '0;
    end else begin
      iorqQ <= iorqN;
      mreqQ <= mreqN;
      m1Q   <= m1N;
      rdQ   <= rdN;
      wrQ   <= wrN;
      d0Q   <= d0;
      btnQ  <= freezeBtn;
      addrQ <= addr;
    end
  end

  logic ioWr, ioRd, memRd, low7Hit;
  assign ioWr    = !iorqQ && !wrQ;
  assign ioRd    = !iorqQ && !rdQ;
  assign memRd   = !mreqQ && !rdQ;
  assign low7Hit = addrQ[6:0] == PAGE_PORT[6:0];

  logic [NUM_DEC-1:0] decNow, decPrev, decEnd;
  logic               a7Prev, d0Prev;

  always_comb begin
    decNow          = '0;
    decNow[D_CLR]   = ioWr && low7Hit;
    decNow[D_HIDE]  = ioWr && (addrQ[7:0] == PAGE_PORT);
    decNow[D_PAGE]  = ioRd && low7Hit && !addrQ[7] && !flg.hidden;
    decNow[D_MODE]  = ioWr && (addrQ[TOP -: 4] == MODE_HI) && (addrQ[7:0] == MODE_LO);
    decNow[D_FETCH] = memRd && !m1Q && (addrQ == NMI_VEC[ADDR_W-1:0])
                      && flg.nmiPend && !flg.allRam;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decPrev <= '0;
      a7Prev  <= 1'b0;
      d0Prev  <= 1'b0;
    end else begin
      decPrev <= decNow;
      a7Prev  <= addrQ[7];
      d0Prev  <= d0Q;
    end
  end

  // Trailing-edge detect per decoded strobe
  for (genvar g = 0; g < NUM_DEC; g++) begin : gEdge
    assign decEnd[g] = decPrev[g] && !decNow[g];
  end

  always_comb begin
    strb            = '0;
    strb.btnPress   = btnQ && !flg.nmiPend;
    strb.nmiClr     = decEnd[D_CLR];
    strb.hideSet    = decEnd[D_HIDE];
    strb.pageLoad   = decEnd[D_PAGE];
    strb.pageVal    = a7Prev;
    strb.allRamLoad = decEnd[D_MODE];
    strb.allRamVal  = d0Prev;
    strb.fetchHit   = decEnd[D_FETCH];
    strb.romHit     = !mreqQ && !addrQ[TOP] && !addrQ[TOP-1] && !addrQ[TOP-2];
    strb.ramHit     = !mreqQ && !addrQ[TOP] && !addrQ[TOP-1] &&  addrQ[TOP-2];
  end

endmodule

// File: rtl/ovl_flag_path.sv
module ovl_flag_path
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ovlStrobe_t strb,
  output ovlFlags_t  flg,
  output logic       nmiN,
  output logic       romCeN,
  output logic       ramCeN
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flg.nmiPend <= 1'b0;
      flg.hidden  <= 1'b1;
      flg.pagedIn <= 1'b0;
      flg.allRam  <= 1'b0;
    end else begin
      if (strb.btnPress) begin
        flg.nmiPend <= 1'b1;
        flg.hidden  <= 1'b0;
      end else begin
        if (strb.nmiClr)  flg.nmiPend <= 1'b0;
        if (strb.hideSet) flg.hidden  <= 1'b1;
      end
      if (strb.fetchHit)      flg.pagedIn <= 1'b1;
      else if (strb.pageLoad) flg.pagedIn <= strb.pageVal;
      if (strb.allRamLoad)    flg.allRam  <= strb.allRamVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiN   <= 1'b1;
      romCeN <= 1'b1;
      ramCeN <= 1'b1;
    end else begin
      nmiN   <= !(flg.nmiPend && !flg.allRam);
      romCeN <= !(flg.pagedIn && strb.romHit);
      ramCeN <= !(flg.pagedIn && strb.ramHit);
    end
  end

endmodule

// File: rtl/snap_pager.sv
module snap_pager
  import ovl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] NMI_VEC   = 16'h0066,
  parameter logic [7:0]  PAGE_PORT = 8'h3F,
  parameter logic [7:0]  MODE_LO   = 8'hFD,
  parameter logic [3:0]  MODE_HI   = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iorqN,
  input  logic              mreqN,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d0,
  input  logic              freezeBtn,
  output logic              nmiN,
  output logic              romCeN,
  output logic              ramCeN
);

  ovlFlags_t  flg;
  ovlStrobe_t strb;

  ovl_bus_ctrl #(
    .ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC), .PAGE_PORT(PAGE_PORT),
    .MODE_LO(MODE_LO), .MODE_HI(MODE_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .iorqN(iorqN), .mreqN(mreqN), .m1N(m1N),
    .rdN(rdN), .wrN(wrN), .addr(addr), .d0(d0), .freezeBtn(freezeBtn),
    .flg(flg), .strb(strb)
  );

  ovl_flag_path u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .flg(flg),
    .nmiN(nmiN), .romCeN(romCeN), .ramCeN(ramCeN)
  );

endmodule

// File: rtl/snap_pager_chk.sv
module snap_pager_chk
  import ovl_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       nmiN,
  input logic       romCeN,
  input logic       ramCeN,
  input ovlFlags_t  flg,
  input ovlStrobe_t strb
);

  // R2
  btn_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flg.nmiPend) |-> $past(strb.btnPress));

  // R3
  nmi_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    flg.allRam |=> nmiN);

  // R4
  page_in_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flg.pagedIn) |-> $past(strb.fetchHit));

  // R5
  pend_clr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flg.nmiPend) |-> $past(strb.nmiClr));

  // R6
  hide_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flg.hidden) |-> $past(strb.hideSet));

  // R9
  ce_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!romCeN && !ramCeN));

  // R9
  ce_needs_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN || !ramCeN) |-> $past(flg.pagedIn));

endmodule

bind snap_pager snap_pager_chk u_chk (
  .clk(clk), .rstN(rstN), .nmiN(nmiN), .romCeN(romCeN), .ramCeN(ramCeN),
  .flg(flg), .strb(strb)
);

// File: tb/snap_pager_bench.sv
`timescale 1ns/1ps
module snap_pager_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iorqN = 1'b1, mreqN = 1'b1, m1N = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [15:0] addr = '0;
  logic        d0 = 1'b0;
  logic        freezeBtn = 1'b0;
  logic        nmiN, romCeN, ramCeN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snap_pager u_snap_pager (
    .clk(clk), .rstN(rstN), .iorqN(iorqN), .mreqN(mreqN), .m1N(m1N),
    .rdN(rdN), .wrN(wrN), .addr(addr), .d0(d0), .freezeBtn(freezeBtn),
    .nmiN(nmiN), .romCeN(romCeN), .ramCeN(ramCeN)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ioWr(input logic [15:0] a, input logic d);
    @(negedge clk);
    addr = a; d0 = d; iorqN = 1'b0; wrN = 1'b0;
    settle(2);
    iorqN = 1'b1; wrN = 1'b1;
    settle(4);
  endtask

  task automatic ioRd(input logic [15:0] a);
    @(negedge clk);
    addr = a; iorqN = 1'b0; rdN = 1'b0;
    settle(2);
    iorqN = 1'b1; rdN = 1'b1;
    settle(4);
  endtask

  task automatic memRd(input logic [15:0] a, input logic fetch);
    @(negedge clk);
    addr = a; mreqN = 1'b0; rdN = 1'b0; m1N = !fetch;
    settle(2);
    mreqN = 1'b1; rdN = 1'b1; m1N = 1'b1;
    settle(4);
  endtask

  task automatic press();
    @(negedge clk);
    freezeBtn = 1'b1;
    settle(3);
    freezeBtn = 1'b0;
    settle(3);
  endtask

  // Hold a memory read, sample both enables, release
  task automatic ceProbe(input logic [15:0] a, input logic expRom,
                         input logic expRam, input string tag);
    @(negedge clk);
    addr = a; mreqN = 1'b0; rdN = 1'b0;
    settle(3);
    chk(romCeN, expRom, {tag, " romCeN"});
    chk(ramCeN, expRam, {tag, " ramCeN"});
    mreqN = 1'b1; rdN = 1'b1;
    settle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(2);

    // R1 reset state
    chk(nmiN, 1'b1, "R1 nmiN after reset");
    ceProbe(16'h0000, 1'b1, 1'b1, "R1 paged out after reset");

    // R2 button raises interrupt
    press();
    chk(nmiN, 1'b0, "R2 nmiN after press");

    // R10 flag waits for strobe release
    @(negedge clk);
    addr = 16'h003F; iorqN = 1'b0; wrN = 1'b0;
    settle(6);
    chk(nmiN, 1'b0, "R10 nmiN held during write");
    iorqN = 1'b1; wrN = 1'b1;
    settle(4);
    chk(nmiN, 1'b1, "R10 R5 nmiN after release");

    // R5 acknowledge decode sweep over single-bit neighbours of 0x3F
    for (int i = 0; i < 9; i++) begin
      logic [7:0] port;
      port = (i == 8) ? 8'h3F : (8'h3F ^ (8'h01 << i));
      press();
      chk(nmiN, 1'b0, "R5 pending before write");
      ioWr({8'h5A, port}, 1'b0);
      chk(nmiN, ((port & 8'h7F) == 8'h3F) ? 1'b1 : 1'b0, "R5 ack sweep");
    end

    // R4 page-in qualification
    press();
    memRd(16'h0066, 1'b0);
    ceProbe(16'h0000, 1'b1, 1'b1, "R4 non-M1 read at vector");
    memRd(16'h0067, 1'b1);
    ceProbe(16'h0000, 1'b1, 1'b1, "R4 M1 read off vector");
    memRd(16'h0066, 1'b1);
    ceProbe(16'h0000, 1'b0, 1'b1, "R4 M1 fetch at vector");

    // R9 chip-enable sweep over upper nibble
    for (int n = 0; n < 16; n++) begin
      logic [3:0] nib;
      nib = 4'(n);
      ceProbe({nib, 12'h123},
              (nib[3:1] == 3'b000) ? 1'b0 : 1'b1,
              (nib[3:1] == 3'b001) ? 1'b0 : 1'b1,
              "R9 enable sweep");
    end

    // R7 read with A7 high ignored
    ioRd(16'h00BF);
    ceProbe(16'h0000, 1'b0, 1'b1, "R7 read 0xBF ignored");
    // R6 hide, then R7 read ignored while hidden
    ioWr(16'h003F, 1'b0);
    ioRd(16'h003F);
    ceProbe(16'h2000, 1'b1, 1'b0, "R6 R7 hidden read ignored");
    // R2 press unhides; R6 write to 0xBF does not hide; R7 read pages out
    press();
    ioWr(16'h00BF, 1'b0);
    ioRd(16'h003F);
    ceProbe(16'h0000, 1'b1, 1'b1, "R6 R7 visible read pages out");
    ceProbe(16'h2000, 1'b1, 1'b1, "R7 RAM off after page-out");

    // R8 and R3 host all-RAM mode
    press();
    chk(nmiN, 1'b0, "R3 nmiN pending, mode clear");
    ioWr(16'h1FFD, 1'b1);
    chk(nmiN, 1'b1, "R8 R3 mode set masks nmiN");
    memRd(16'h0066, 1'b1);
    ceProbe(16'h0000, 1'b1, 1'b1, "R8 mode blocks page-in");
    ioWr(16'h2FFD, 1'b0);
    chk(nmiN, 1'b1, "R8 wrong nibble ignored");
    ioWr(16'h1AFD, 1'b0);
    chk(nmiN, 1'b0, "R8 mode cleared, middle bits ignored");
    memRd(16'h0066, 1'b1);
    ceProbe(16'h2000, 1'b1, 1'b0, "R4 page-in after mode clear");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule